// File: doc/BRIEF.md
# Display Controller Register Bank with Set/Clear Aliases

This block holds the control and timing words of a display controller and hands their fields to the datapath, the sync generator and the FIFO logic as plain wires. Software reaches each 32-bit word through three addresses. The base address replaces the word. The base plus 4 ORs the write data into it. The base plus 8 clears the bits that are set in the write data. A driver can therefore start or stop the engine, or flip any single bit, with one write and no read-modify-write.

Words sit on a 16-byte stride in this order:
- the main control word;
- the auxiliary control word, which holds the byte-valid mask and the FIFO-clear strobe;
- the transfer-count word;
- a parameterised number of timing words.

A read returns the stored value. The run bit is also driven out continuously as a live status line. A soft-reset bit in the main word clears all other state and holds it at zero until software clears that bit through the clear alias.

The bus bridge in front of the bank is outside this block. It presents a single-cycle write strobe, a byte address and the write data, and it reads the combinational read-data port.

Top module: `dc_regbank`

## Requirements
- R1: After reset every mapped word reads as zero and every field output is zero.
- R2: A write to a word's base address (offset 0x0 within its 16-byte slot) replaces the whole word from the next clock edge. A read at that address returns the new value.
- R3: A write to base+0x4 ORs the write data into the word.
- R4: A write to base+0x8 clears every bit of the word that is 1 in the write data, leaving the other bits as they were.
- R5: Word slots sit at address bits [ADDR_W-1:4] in this order:
  - slot 0 (0x00): main control;
  - slot 1 (0x10): auxiliary control;
  - slot 2 (0x20): transfer count;
  - slots 3 onward (0x30 upward): timing words 0 to NUM_TIMING-1.
- R6: Main control field positions:
  - bit 0: run, also driven live on `ctl_run`;
  - bit 5: master;
  - bits 9:8: word length (0 = 16-bit, 3 = 24-bit in a 32-bit word);
  - bits 11:10: bus width (0 = 16, 1 = 8, 2 = 18, 3 = 24);
  - bit 17: dot-clock mode;
  - bit 18: vsync mode;
  - bit 19: bypass count;
  - bit 30: clock gate;
  - bit 31: soft reset.
- R7: Auxiliary control fields:
  - Bits 19:16 form the byte-valid mask on `byte_mask`. The value 0xF selects packed 16-bit pixels and 0x7 selects one pixel per word.
  - Writing a 1 to bit 21 through the base or set address raises `fifo_clr` for exactly the one cycle after the write edge.
  - Bit 21 is never stored and always reads 0. A clear-alias write produces no pulse.
- R8: The transfer-count word drives `line_count` from bits 31:16 and `pixel_count` from bits 15:0.
- R9: Soft reset behaves as follows:
  - At the edge where a write leaves main bit 31 set, all other main bits and all other words become zero, and no `fifo_clr` pulse is produced.
  - While bit 31 stays set, writes to other words are ignored.
  - A clear-alias write of bit 31 ends the soft reset.
- R10: These accesses are unmapped:
  - sub-offset 0xC;
  - a slot index at or beyond 3+NUM_TIMING;
  - a non-zero address bits [1:0].

  An unmapped access reads as zero and a write to it changes nothing.
- R11: Reads at the set and clear aliases of a mapped word return the stored value, the same as a read at the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| addr | input | ADDR_W | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| ctl_run | output | 1 | Run bit, live |
| ctl_master | output | 1 | Master select |
| ctl_word_len | output | 2 | Input word length code |
| ctl_bus_width | output | 2 | Output bus width code |
| ctl_dotclk_mode | output | 1 | Dot-clock mode select |
| ctl_vsync_mode | output | 1 | Vsync mode select |
| ctl_bypass_cnt | output | 1 | Bypass count select |
| ctl_clk_gate | output | 1 | Clock gate request |
| ctl_soft_rst | output | 1 | Soft reset held |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |
| byte_mask | output | 4 | Byte-valid mask |
| line_count | output | 16 | Vertical line count |
| pixel_count | output | 16 | Horizontal pixel count |
| timing_words | output | 32*NUM_TIMING | Timing words, word 0 in the low bits |

## Verification
A vector table applies base, set and clear writes in turn to the transfer-count word and to the timing words, starting from all-ones, all-zeros and alternating-bit values. Because each data pattern overlaps the previous contents differently, a replace, OR and AND-NOT mix-up gives a different read-back. Directed cases:
- a main-word pattern with every named field set to a distinct value, which exposes swapped field positions;
- FIFO strobes through each of the three aliases, which separate pulse from no pulse;
- unmapped and misaligned accesses placed next to live words;
- writes made while soft reset is held and again after it is released.

// File: rtl/dc_regbank_pkg.sv
package dc_regbank_pkg;

  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } acc_op_e;

  localparam int WORD_W    = 32;
  localparam int SLOT_MAIN = 0;
  localparam int SLOT_AUX  = 1;
  localparam int SLOT_CNT  = 2;
  localparam int SLOT_TIM0 = 3;

  localparam int B_RUN     = 0;
  localparam int B_MASTER  = 5;
  localparam int B_WLEN_LO = 8;
  localparam int B_BUSW_LO = 10;
  localparam int B_DOTCLK  = 17;
  localparam int B_VSYNC   = 18;
  localparam int B_BYPASS  = 19;
  localparam int B_CGATE   = 30;
  localparam int B_SRST    = 31;

  localparam int B_MASK_LO = 16;
  localparam int B_FCLR    = 21;

  localparam logic [WORD_W-1:0] SRST_ONLY = WORD_W'(1) << B_SRST;
  localparam logic [WORD_W-1:0] AUX_KEEP  = ~(WORD_W'(1) << B_FCLR);

  function automatic logic [WORD_W-1:0] apply_access(input acc_op_e op,
                                                     input logic [WORD_W-1:0] cur,
                                                     input logic [WORD_W-1:0] din);
    case (op)
      OP_PUT:  return din;
      OP_SET:  return cur | din;
      OP_CLR:  return cur & ~din;
      default: return cur;
    endcase
  endfunction

  function automatic logic next_bit(input acc_op_e op, input logic cur, input logic din);
    case (op)
      OP_PUT:  return din;
      OP_SET:  return cur | din;
      OP_CLR:  return cur & ~din;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/dc_rb_decode.sv
module dc_rb_decode
  import dc_regbank_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output acc_op_e           op,
  output logic              hit
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;

  assign slot = addr[ADDR_W-1:4];
  assign idx  = slot[IDX_W-1:0];
  assign op   = acc_op_e'(addr[3:2]);
  assign hit  = (slot < SLOT_W'(NUM_REGS)) && (addr[3:2] != 2'd3) && (addr[1:0] == 2'd0);
endmodule

// File: rtl/dc_rb_word.sv
module dc_rb_word
  import dc_regbank_pkg::*;
#(
  parameter logic [31:0] KEEP    = 32'hFFFF_FFFF,
  parameter bit          IS_CTRL = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  acc_op_e     op,
  input  logic [31:0] din,
  input  logic        hold_zero,
  output logic [31:0] q
);
  logic [31:0] nxt;
  logic [31:0] raw;

  assign raw = (we ? apply_access(op, q, din) : q) & KEEP;

  generate
    if (IS_CTRL) begin : g_ctrl
      always_comb begin
        nxt = raw;
        if (raw[B_SRST] | hold_zero) nxt = raw & SRST_ONLY;
      end
    end else begin : g_plain
      always_comb begin
        nxt = raw;
        if (hold_zero) nxt = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/dc_regbank.sv
module dc_regbank
  import dc_regbank_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_TIMING = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output logic                     ctl_run,
  output logic                     ctl_master,
  output logic [1:0]               ctl_word_len,
  output logic [1:0]               ctl_bus_width,
  output logic                     ctl_dotclk_mode,
  output logic                     ctl_vsync_mode,
  output logic                     ctl_bypass_cnt,
  output logic                     ctl_clk_gate,
  output logic                     ctl_soft_rst,
  output logic                     fifo_clr,
  output logic [3:0]               byte_mask,
  output logic [15:0]              line_count,
  output logic [15:0]              pixel_count,
  output logic [32*NUM_TIMING-1:0] timing_words
);
  localparam int NUM_REGS = SLOT_TIM0 + NUM_TIMING;
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic [IDX_W-1:0] acc_idx;
  acc_op_e          acc_op;
  logic             acc_hit;
  logic             wr_hit;
  logic             srst_nx;
  logic             fclr_q;
  logic [31:0]      word_q [NUM_REGS];

  dc_rb_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
    .addr (addr),
    .idx  (acc_idx),
    .op   (acc_op),
    .hit  (acc_hit)
  );

  assign wr_hit  = wr_en && acc_hit;
  assign srst_nx = (wr_hit && acc_idx == IDX_W'(SLOT_MAIN))
                   ? next_bit(acc_op, word_q[SLOT_MAIN][B_SRST], wdata[B_SRST])
                   : word_q[SLOT_MAIN][B_SRST];

  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
      dc_rb_word #(
        .KEEP    ((k == SLOT_AUX) ? AUX_KEEP : 32'hFFFF_FFFF),
        .IS_CTRL (k == SLOT_MAIN)
      ) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_hit && acc_idx == IDX_W'(k)),
        .op        (acc_op),
        .din       (wdata),
        .hold_zero ((k == SLOT_MAIN) ? 1'b0 : srst_nx),
        .q         (word_q[k])
      );
    end
    for (genvar t = 0; t < NUM_TIMING; t++) begin : g_tim
      assign timing_words[32*t +: 32] = word_q[SLOT_TIM0 + t];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fclr_q <= 1'b0;
    else        fclr_q <= wr_hit && acc_idx == IDX_W'(SLOT_AUX) && acc_op != OP_CLR
                          && wdata[B_FCLR] && !srst_nx;
  end

  assign rdata           = acc_hit ? word_q[acc_idx] : '0;
  assign fifo_clr        = fclr_q;
  assign ctl_run         = word_q[SLOT_MAIN][B_RUN];
  assign ctl_master      = word_q[SLOT_MAIN][B_MASTER];
  assign ctl_word_len    = word_q[SLOT_MAIN][B_WLEN_LO +: 2];
  assign ctl_bus_width   = word_q[SLOT_MAIN][B_BUSW_LO +: 2];
  assign ctl_dotclk_mode = word_q[SLOT_MAIN][B_DOTCLK];
  assign ctl_vsync_mode  = word_q[SLOT_MAIN][B_VSYNC];
  assign ctl_bypass_cnt  = word_q[SLOT_MAIN][B_BYPASS];
  assign ctl_clk_gate    = word_q[SLOT_MAIN][B_CGATE];
  assign ctl_soft_rst    = word_q[SLOT_MAIN][B_SRST];
  assign byte_mask       = word_q[SLOT_AUX][B_MASK_LO +: 4];
  assign line_count      = word_q[SLOT_CNT][31:16];
  assign pixel_count     = word_q[SLOT_CNT][15:0];
endmodule

// File: rtl/dc_regbank_chk.sv
module dc_regbank_chk
  import dc_regbank_pkg::*;
#(
  parameter int IDX_W      = 3,
  parameter int NUM_TIMING = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     wr_hit,
  input logic                     acc_hit,
  input logic [IDX_W-1:0]         acc_idx,
  input acc_op_e                  acc_op,
  input logic [31:0]              wdata,
  input logic [31:0]              rdata,
  input logic                     ctl_soft_rst,
  input logic                     fifo_clr,
  input logic [3:0]               byte_mask,
  input logic [15:0]              line_count,
  input logic [15:0]              pixel_count,
  input logic [32*NUM_TIMING-1:0] timing_words
);
  // R3: set alias ORs into the transfer-count word
  p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && acc_op == OP_SET && acc_idx == IDX_W'(SLOT_CNT) && !ctl_soft_rst)
    |=> ({line_count, pixel_count} == ($past({line_count, pixel_count}) | $past(wdata))));

  // R4: clear alias removes the data bits
  p_clr_andnot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && acc_op == OP_CLR && acc_idx == IDX_W'(SLOT_CNT) && !ctl_soft_rst)
    |=> ({line_count, pixel_count} == ($past({line_count, pixel_count}) & ~$past(wdata))));

  // R10: unmapped reads return zero
  p_unmapped_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> rdata == 32'd0);

  // R10: unmapped writes leave state alone
  p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_hit) |=> ($stable({line_count, pixel_count}) && $stable(timing_words)
                             && $stable(byte_mask)));

  // R9: all other words held at zero during soft reset
  p_srst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_soft_rst |-> (line_count == 16'd0 && pixel_count == 16'd0
                      && timing_words == '0 && byte_mask == 4'd0));

  // R7: a FIFO clear pulse follows an aux write carrying bit 21
  p_fifo_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |-> $past(wr_hit && acc_idx == IDX_W'(SLOT_AUX) && wdata[B_FCLR]
                       && acc_op != OP_CLR));

  // R7: FIFO clear bit never reads back
  p_fifo_bit_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && acc_idx == IDX_W'(SLOT_AUX)) |-> !rdata[B_FCLR]);
endmodule

bind dc_regbank dc_regbank_chk #(.IDX_W(IDX_W), .NUM_TIMING(NUM_TIMING)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_hit       (wr_hit),
  .acc_hit      (acc_hit),
  .acc_idx      (acc_idx),
  .acc_op       (acc_op),
  .wdata        (wdata),
  .rdata        (rdata),
  .ctl_soft_rst (ctl_soft_rst),
  .fifo_clr     (fifo_clr),
  .byte_mask    (byte_mask),
  .line_count   (line_count),
  .pixel_count  (pixel_count),
  .timing_words (timing_words)
);

// File: tb/dc_regbank_tb.sv
module dc_regbank_tb;
  localparam int ADDR_W = 12;
  localparam int NT     = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic ctl_run, ctl_master, ctl_dotclk_mode, ctl_vsync_mode, ctl_bypass_cnt;
  logic ctl_clk_gate, ctl_soft_rst, fifo_clr;
  logic [1:0]  ctl_word_len, ctl_bus_width;
  logic [3:0]  byte_mask;
  logic [15:0] line_count, pixel_count;
  logic [32*NT-1:0] timing_words;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dc_regbank #(.ADDR_W(ADDR_W), .NUM_TIMING(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ctl_run(ctl_run), .ctl_master(ctl_master), .ctl_word_len(ctl_word_len),
    .ctl_bus_width(ctl_bus_width), .ctl_dotclk_mode(ctl_dotclk_mode),
    .ctl_vsync_mode(ctl_vsync_mode), .ctl_bypass_cnt(ctl_bypass_cnt),
    .ctl_clk_gate(ctl_clk_gate), .ctl_soft_rst(ctl_soft_rst), .fifo_clr(fifo_clr),
    .byte_mask(byte_mask), .line_count(line_count), .pixel_count(pixel_count),
    .timing_words(timing_words)
  );

  // {write address, write data, expected read at slot base}
  localparam logic [95:0] VEC [8] = '{
    {32'h020, 32'h1234_5678, 32'h1234_5678},
    {32'h024, 32'h0000_8001, 32'h1234_D679},
    {32'h028, 32'h1030_0008, 32'h0204_D671},
    {32'h030, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h038, 32'h0F0F_0F0F, 32'hF0F0_F0F0},
    {32'h074, 32'h0000_00A5, 32'h0000_00A5},
    {32'h070, 32'h5A5A_0000, 32'h5A5A_0000},
    {32'h03C, 32'h0000_0001, 32'hF0F0_F0F0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1;
    check(rdata === exp, req, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int s = 0; s < 3 + NT; s++) rd_chk(32'(s * 16), 32'h0, "R1 reset word");
    check({ctl_run, ctl_soft_rst, fifo_clr, byte_mask, line_count} == '0, "R1 outputs",
          32'({ctl_run, ctl_soft_rst, fifo_clr, byte_mask}), 32'h0);

    // R2 R3 R4 R5 R10: vector table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][95:64], VEC[i][63:32]);
      rd_chk(VEC[i][95:64] & ~32'hF, VEC[i][31:0], "R2/R3/R4/R5 vector");
    end
    check(timing_words[32*4 +: 32] == 32'h5A5A_0000, "R5 timing slot 4", timing_words[32*4 +: 32], 32'h5A5A_0000);

    // R6: main control fields
    wr(32'h000, 32'h400E_0B21);
    check({ctl_clk_gate, ctl_bypass_cnt, ctl_vsync_mode, ctl_dotclk_mode, ctl_bus_width,
           ctl_word_len, ctl_master, ctl_run, ctl_soft_rst} == 11'b1111_10_11_110,
          "R6 fields", 32'({ctl_clk_gate, ctl_bypass_cnt, ctl_vsync_mode, ctl_dotclk_mode,
          ctl_bus_width, ctl_word_len, ctl_master, ctl_run, ctl_soft_rst}), 32'h7DE);
    wr(32'h008, 32'h0000_0001);
    check(ctl_run == 1'b0, "R6 run live after clear", 32'(ctl_run), 32'h0);
    rd_chk(32'h000, 32'h400E_0B20, "R4 main clear");
    rd_chk(32'h004, 32'h400E_0B20, "R11 set alias read");
    rd_chk(32'h008, 32'h400E_0B20, "R11 clear alias read");

    // R8: transfer count split
    wr(32'h020, 32'h01E0_0280);
    check(line_count == 16'h01E0 && pixel_count == 16'h0280, "R8 counts",
          {line_count, pixel_count}, 32'h01E0_0280);

    // R7: FIFO clear pulse and byte mask
    wr(32'h010, 32'h002F_0000);
    check(fifo_clr == 1'b1, "R7 pulse after base write", 32'(fifo_clr), 32'h1);
    @(negedge clk);
    check(fifo_clr == 1'b0, "R7 pulse one cycle", 32'(fifo_clr), 32'h0);
    check(byte_mask == 4'hF, "R7 mask", 32'(byte_mask), 32'hF);
    rd_chk(32'h010, 32'h000F_0000, "R7 bit21 reads zero");
    wr(32'h018, 32'h0020_0000);
    check(fifo_clr == 1'b0, "R7 no pulse via clear alias", 32'(fifo_clr), 32'h0);
    wr(32'h014, 32'h0020_0000);
    check(fifo_clr == 1'b1, "R7 pulse via set alias", 32'(fifo_clr), 32'h1);
    wr(32'h018, 32'h0008_0000);
    check(byte_mask == 4'h7, "R7 mask one pixel per word", 32'(byte_mask), 32'h7);

    // R10: unmapped and misaligned
    rd_chk(32'h00C, 32'h0, "R10 sub-offset C read");
    rd_chk(32'h080, 32'h0, "R10 beyond last slot read");
    rd_chk(32'h022, 32'h0, "R10 misaligned read");
    wr(32'h02C, 32'hFFFF_FFFF);
    wr(32'h021, 32'h0);
    rd_chk(32'h020, 32'h01E0_0280, "R10 unmapped write ignored");
    wr(32'h0F0, 32'h1111_1111);
    check(timing_words[31:0] == 32'hF0F0_F0F0, "R10 far write ignored", timing_words[31:0], 32'hF0F0_F0F0);

    // R9: soft reset
    wr(32'h004, 32'h8000_0000);
    rd_chk(32'h000, 32'h8000_0000, "R9 main keeps only soft reset");
    rd_chk(32'h020, 32'h0, "R9 count cleared");
    rd_chk(32'h030, 32'h0, "R9 timing cleared");
    check(byte_mask == 4'h0 && ctl_soft_rst, "R9 mask cleared", 32'(byte_mask), 32'h0);
    wr(32'h020, 32'h0000_0055);
    rd_chk(32'h020, 32'h0, "R9 write ignored while held");
    wr(32'h008, 32'h8000_0000);
    rd_chk(32'h000, 32'h0, "R9 released by clear alias");
    wr(32'h020, 32'h0000_0077);
    rd_chk(32'h020, 32'h0000_0077, "R9 writes accepted after release");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule